// File: doc/BRIEF.md
# Issue Stall and Dependency Barrier Gate

This block sits at the issue stage of a simple in-order shader core. Each cycle it looks at the instruction on offer, a 128-bit word whose top bits hold a scheduling control field, and decides whether that instruction may issue. The control field carries four things the block acts on: a compiler-chosen stall count, a batch value, a release-barrier index and a wait mask. It also carries operand reuse flags, which the block does not use.

After an issue, a countdown enforces the fixed stall before the next issue. Six dependency barrier flags track variable-latency producers. An issuing instruction sets the flag named by its release index, and a completion pulse from a variable-latency unit clears it. While any barrier chosen by the presented instruction's wait mask is still set, issue is held.

The block also checks each issued control field against its encoding rules. Stalls above 15 share encoding bits with the batch value, so they are legal only when the batch value is zero. On an illegal combination the block raises an error and falls back to safe values.

Top module: `issue_gate`

## Requirements
- R1: After reset, issue_en is 1 with no instruction waiting, bar_busy is 0, ctrl_err is 0 and grp_tag is 0.
- R2: An instruction issues in a cycle where instr_valid and issue_en are both 1. Control field layout within the top 24 bits of the word (bit 104 upward): stall [4:0], batch [7:5], release index [10:8], wait mask [16:11], reuse flags [20:17], with the upper bits reserved.
- R3: After an issue with effective stall N, issue_en stays 0 for exactly N cycles and returns to 1 in the following cycle. A stall of 0 allows issue in the very next cycle.
- R4: An issued instruction with a release index from 0 to 5 sets bar_busy[index] from the next cycle onward.
- R5: A release index of 6 or 7 sets no barrier. The value 7 is the normal "no barrier" code.
- R6: A completion pulse (cmpl_valid with cmpl_idx from 0 to 5) clears that barrier from the next cycle onward.
- R7: While instr_valid is 1 and the wait mask selects any barrier that is set, issue_en is 0.
- R8: If a barrier is set by an issue and cleared by a completion in the same cycle, the set wins and the barrier stays set.
- R9: A stall up to 27 with batch 0, or a stall up to 15 with a batch from 0 to 6, is legal. It is used as given, ctrl_err is 0 the next cycle, and grp_tag shows the batch.
- R10: An issued stall above 15 with a nonzero batch raises ctrl_err for one cycle. The block then uses a stall of 15 and batch 0.
- R11: A batch value of 7 raises ctrl_err and is replaced by batch 0. A stall above 27 raises ctrl_err and is clamped to 27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is on offer |
| instr_word | input | 128 | Instruction word; control field in the top 24 bits |
| cmpl_valid | input | 1 | Completion pulse from a variable-latency unit |
| cmpl_idx | input | 3 | Barrier index released by the completion |
| issue_en | output | 1 | Offered instruction may issue this cycle |
| bar_busy | output | 6 | Barrier flags currently set |
| ctrl_err | output | 1 | Last issued control field was illegal |
| grp_tag | output | 3 | Effective batch of the last issued instruction |

## Verification
A stall counter loaded with the wrong value shows up at once as the wrong number of low cycles on issue_en after an issue. Each table vector measures that gap to the exact cycle. A barrier flag that is set or cleared wrongly appears on bar_busy one cycle after the issue or completion. It then shows up as issue_en staying low, or rising too early, for an instruction waiting on that flag. An error in the fallback logic appears one cycle after the issue, both on ctrl_err and grp_tag and in the length of the following stall gap.

// File: rtl/issue_gate_pkg.sv
package issue_gate_pkg;
  localparam int INSTR_W  = 128;
  localparam int CTRL_W   = 24;
  localparam int STALL_W  = 5;
  localparam int BATCH_W  = 3;
  localparam int IDX_W    = 3;
  localparam int NBAR     = 6;
  localparam int REUSE_W  = 4;
  localparam int BASE_MAX = 15;
  localparam int EXT_MAX  = 27;
  localparam int BATCH_BAD = 7;

  localparam int RSV_W = CTRL_W - STALL_W - BATCH_W - IDX_W - NBAR - REUSE_W;

  typedef struct packed {
    logic [RSV_W-1:0]   rsv;
    logic [REUSE_W-1:0] reuse;
    logic [NBAR-1:0]    wait_mask;
    logic [IDX_W-1:0]   rel_idx;
    logic [BATCH_W-1:0] batch;
    logic [STALL_W-1:0] stall;
  } sched_ctrl_t;

  typedef struct packed {
    logic [STALL_W-1:0] stall;
    logic [BATCH_W-1:0] batch;
    logic               bad;
  } legal_ctrl_t;
endpackage

// File: rtl/ctrl_legalizer.sv
module ctrl_legalizer
  import issue_gate_pkg::*;
(
  input  sched_ctrl_t ctrl_i,
  output legal_ctrl_t legal_o
);
  logic [STALL_W-1:0] st_a, st_b;
  logic [BATCH_W-1:0] bt_a, bt_b;
  logic               bad_batch, bad_mix, bad_range;

  always_comb begin
    bad_batch = (ctrl_i.batch == BATCH_W'(BATCH_BAD));
    bt_a      = bad_batch ? '0 : ctrl_i.batch;
    st_a      = ctrl_i.stall;

    bad_mix   = (st_a > STALL_W'(BASE_MAX)) && (bt_a != '0);
    st_b      = bad_mix ? STALL_W'(BASE_MAX) : st_a;
    bt_b      = bad_mix ? '0 : bt_a;

    bad_range = (st_b > STALL_W'(EXT_MAX));

    legal_o.stall = bad_range ? STALL_W'(EXT_MAX) : st_b;
    legal_o.batch = bt_b;
    legal_o.bad   = bad_batch | bad_mix | bad_range;
  end
endmodule

// File: rtl/stall_timer.sv
module stall_timer
  import issue_gate_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [STALL_W-1:0] value_i,
  output logic               done_o
);
  logic [STALL_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load_i)       cnt_q <= value_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/barrier_file.sv
module barrier_file
  import issue_gate_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] clr_idx_i,
  output logic [NBAR-1:0]  busy_o
);
  for (genvar b = 0; b < NBAR; b++) begin : g_bar
    logic set_b, clr_b, q;
    assign set_b = set_en_i && (set_idx_i == IDX_W'(b));
    assign clr_b = clr_en_i && (clr_idx_i == IDX_W'(b));
    always_ff @(posedge clk) begin
      if (rst)        q <= 1'b0;
      else if (set_b) q <= 1'b1;
      else if (clr_b) q <= 1'b0;
    end
    assign busy_o[b] = q;
  end
endmodule

// File: rtl/issue_gate.sv
module issue_gate
  import issue_gate_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               instr_valid,
  input  logic [INSTR_W-1:0] instr_word,
  input  logic               cmpl_valid,
  input  logic [IDX_W-1:0]   cmpl_idx,
  output logic               issue_en,
  output logic [NBAR-1:0]    bar_busy,
  output logic               ctrl_err,
  output logic [BATCH_W-1:0] grp_tag
);
  sched_ctrl_t ctrl;
  legal_ctrl_t legal;
  logic        stall_done, wait_hold, fire;
  logic [NBAR-1:0] busy;

  assign ctrl = sched_ctrl_t'(instr_word[INSTR_W-1 -: CTRL_W]);

  ctrl_legalizer u_legal (.ctrl_i(ctrl), .legal_o(legal));

  stall_timer u_timer (
    .clk(clk), .rst(rst), .load_i(fire),
    .value_i(legal.stall), .done_o(stall_done)
  );

  barrier_file u_bars (
    .clk(clk), .rst(rst),
    .set_en_i(fire && (ctrl.rel_idx < IDX_W'(NBAR))),
    .set_idx_i(ctrl.rel_idx),
    .clr_en_i(cmpl_valid && (cmpl_idx < IDX_W'(NBAR))),
    .clr_idx_i(cmpl_idx),
    .busy_o(busy)
  );

  assign wait_hold = instr_valid && ((ctrl.wait_mask & busy) != '0);
  assign issue_en  = stall_done && !wait_hold;
  assign fire      = instr_valid && issue_en;
  assign bar_busy  = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_err <= 1'b0;
      grp_tag  <= '0;
    end else begin
      ctrl_err <= fire && legal.bad;
      if (fire) grp_tag <= legal.batch;
    end
  end
endmodule

// File: rtl/issue_gate_chk.sv
module issue_gate_chk
  import issue_gate_pkg::*;
(
  input logic               clk,
  input logic               rst,
  input logic               instr_valid,
  input logic [INSTR_W-1:0] instr_word,
  input logic               cmpl_valid,
  input logic [IDX_W-1:0]   cmpl_idx,
  input logic               issue_en,
  input logic [NBAR-1:0]    bar_busy,
  input logic               ctrl_err
);
  sched_ctrl_t c;
  logic fire;
  assign c    = sched_ctrl_t'(instr_word[INSTR_W-1 -: CTRL_W]);
  assign fire = instr_valid && issue_en;

  a_r3_stall_blocks: assert property (@(posedge clk) disable iff (rst)
    (fire && c.stall != '0) |=> !issue_en);

  a_r4_bar_set: assert property (@(posedge clk) disable iff (rst)
    (fire && c.rel_idx < IDX_W'(NBAR)) |=> bar_busy[$past(c.rel_idx)]);

  a_r5_no_set: assert property (@(posedge clk) disable iff (rst)
    (fire && c.rel_idx >= IDX_W'(NBAR) && !cmpl_valid) |=> $stable(bar_busy));

  a_r6_bar_clear: assert property (@(posedge clk) disable iff (rst)
    (cmpl_valid && cmpl_idx < IDX_W'(NBAR) && !(fire && c.rel_idx == cmpl_idx))
      |=> !bar_busy[$past(cmpl_idx)]);

  a_r7_wait_hold: assert property (@(posedge clk) disable iff (rst)
    (instr_valid && (c.wait_mask & bar_busy) != '0) |-> !issue_en);

  a_r10_bad_mix: assert property (@(posedge clk) disable iff (rst)
    (fire && c.stall > STALL_W'(BASE_MAX) && c.batch != '0) |=> ctrl_err);
endmodule

bind issue_gate issue_gate_chk u_chk (
  .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
  .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .issue_en(issue_en),
  .bar_busy(bar_busy), .ctrl_err(ctrl_err)
);

// File: tb/issue_gate_tb_top.sv
`timescale 1ns/1ps
module issue_gate_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         instr_valid = 1'b0;
  logic [127:0] instr_word = '0;
  logic         cmpl_valid = 1'b0;
  logic [2:0]   cmpl_idx = '0;
  logic         issue_en;
  logic [5:0]   bar_busy;
  logic         ctrl_err;
  logic [2:0]   grp_tag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  issue_gate dut_i (
    .clk(clk), .rst(rst), .instr_valid(instr_valid), .instr_word(instr_word),
    .cmpl_valid(cmpl_valid), .cmpl_idx(cmpl_idx), .issue_en(issue_en),
    .bar_busy(bar_busy), .ctrl_err(ctrl_err), .grp_tag(grp_tag)
  );

  // {stall, batch, exp_stall, exp_batch, exp_err}
  localparam logic [16:0] VEC [10] = '{
    {5'd5,  3'd3, 5'd5,  3'd3, 1'b0},
    {5'd0,  3'd0, 5'd0,  3'd0, 1'b0},
    {5'd15, 3'd6, 5'd15, 3'd6, 1'b0},
    {5'd20, 3'd0, 5'd20, 3'd0, 1'b0},
    {5'd27, 3'd0, 5'd27, 3'd0, 1'b0},
    {5'd20, 3'd2, 5'd15, 3'd0, 1'b1},
    {5'd16, 3'd1, 5'd15, 3'd0, 1'b1},
    {5'd31, 3'd0, 5'd27, 3'd0, 1'b1},
    {5'd3,  3'd7, 5'd3,  3'd0, 1'b1},
    {5'd31, 3'd7, 5'd27, 3'd0, 1'b1}
  };

  function automatic logic [127:0] mk(input logic [4:0] st, input logic [2:0] bt,
                                      input logic [2:0] rel, input logic [5:0] wm,
                                      input logic [3:0] ru);
    logic [23:0] c;
    c = {3'b000, ru, wm, rel, bt, st};
    return {c, 104'h0};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Offer and issue one instruction; returns at the negedge after the issue edge.
  task automatic issue_one(input logic [127:0] w, input string req);
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = w;
    #1 check(req, int'(issue_en), 1);
    @(posedge clk);
    #1 instr_valid = 1'b0;
    instr_word = '0;
    @(negedge clk);
  endtask

  // Count low cycles of issue_en starting at the current negedge.
  task automatic gap(output int n);
    n = 0;
    while (!issue_en && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int g;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 issue_en", int'(issue_en), 1);
    check("R1 bar_busy", int'(bar_busy), 0);
    check("R1 ctrl_err", int'(ctrl_err), 0);
    check("R1 grp_tag", int'(grp_tag), 0);

    // R2 R3 R9 R10 R11: table of stall/batch vectors
    foreach (VEC[i]) begin
      issue_one(mk(VEC[i][16:12], VEC[i][11:9], 3'd7, 6'd0, 4'hF), "R2 issue");
      check(VEC[i][0] ? "R10/R11 err" : "R9 err", int'(ctrl_err), int'(VEC[i][0]));
      check("R9 grp_tag", int'(grp_tag), int'(VEC[i][3:1]));
      gap(g);
      check("R3 stall gap", g, int'(VEC[i][8:4]));
    end

    // R4 set barrier 2; R5 no set for 7 and 6
    issue_one(mk(5'd0, 3'd0, 3'd2, 6'd0, 4'h0), "R4 issue");
    check("R4 bar2 set", int'(bar_busy), 6'b000100);
    issue_one(mk(5'd0, 3'd0, 3'd7, 6'd0, 4'h0), "R5 issue");
    check("R5 idx7 no set", int'(bar_busy), 6'b000100);
    issue_one(mk(5'd0, 3'd0, 3'd6, 6'd0, 4'h0), "R5 issue");
    check("R5 idx6 no set", int'(bar_busy), 6'b000100);

    // R7 hold while waiting on barrier 2, unrelated wait bit passes
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = mk(5'd0, 3'd0, 3'd7, 6'b000100, 4'h0);
    #1 check("R7 hold", int'(issue_en), 0);
    instr_word  = mk(5'd0, 3'd0, 3'd7, 6'b111011, 4'h0);
    #1 check("R7 other mask", int'(issue_en), 1);
    instr_word  = mk(5'd0, 3'd0, 3'd7, 6'b000100, 4'h0);
    @(negedge clk);
    #1 check("R7 still held", int'(issue_en), 0);
    // R6 completion clears barrier 2, issue resumes next cycle
    cmpl_valid = 1'b1; cmpl_idx = 3'd2;
    @(posedge clk);
    #1 cmpl_valid = 1'b0;
    #1 check("R6 bar2 cleared", int'(bar_busy), 0);
    check("R6 issue after clear", int'(issue_en), 1);
    @(negedge clk);
    instr_valid = 1'b0; instr_word = '0;

    // R8 set and clear of barrier 3 in one cycle
    issue_one(mk(5'd0, 3'd0, 3'd3, 6'd0, 4'h0), "R8 first");
    check("R8 bar3 set", int'(bar_busy), 6'b001000);
    @(negedge clk);
    instr_valid = 1'b1;
    instr_word  = mk(5'd0, 3'd0, 3'd3, 6'd0, 4'h0);
    cmpl_valid  = 1'b1; cmpl_idx = 3'd3;
    @(posedge clk);
    #1 instr_valid = 1'b0; cmpl_valid = 1'b0; instr_word = '0;
    @(negedge clk);
    check("R8 set wins", int'(bar_busy), 6'b001000);

    // R6 completion with index 7 changes nothing, then real clear
    cmpl_valid = 1'b1; cmpl_idx = 3'd7;
    @(negedge clk);
    check("R6 idx7 no clear", int'(bar_busy), 6'b001000);
    cmpl_idx = 3'd3;
    @(negedge clk);
    cmpl_valid = 1'b0;
    check("R6 bar3 cleared", int'(bar_busy), 0);

    // R1 reset mid-stall restores idle state
    issue_one(mk(5'd10, 3'd0, 3'd1, 6'd0, 4'h0), "R1 pre");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset issue_en", int'(issue_en), 1);
    check("R1 reset bars", int'(bar_busy), 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule